// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 8-bit bidirectional buses, called A and B. Each direction of travel has its own holding register and its own capture clock. The A-to-B register samples the A bus on a rising edge of its clock. The B-to-A register samples the B bus on a rising edge of its own clock. Each direction also has a source select. It decides whether the outgoing value is the live value from the opposite bus or the value held in that direction's register.

An active-low enable and a direction input decide which bus, if either, the block drives. When the enable is high, both buses are inputs only. The registers still capture on their clock edges, so data can be stored while the outputs are quiet and sent out later.

Each bus pin is split into an input, an output value and an output-enable, which keeps the block synthesizable. The output value always shows the selected source. The output-enable says whether that value is actually placed on the bus.

Top module: `regxcvr_top`

## Requirements
- R1: On each rising edge of `clk_ab`, the value on `a_in` is stored in the A-to-B register.
- R2: On each rising edge of `clk_ba`, the value on `b_in` is stored in the B-to-A register.
- R3: While `oe_n` is 1, both `a_oe` and `b_oe` are 0.
- R4: While `oe_n` is 0, `dir` = 1 gives `b_oe` = 1 and `a_oe` = 0, and `dir` = 0 gives `a_oe` = 1 and `b_oe` = 0.
- R5: `b_out` equals `a_in` when `sel_ab` = 0 (live) and equals the A-to-B register when `sel_ab` = 1 (stored). The live path is combinational.
- R6: `a_out` equals `b_in` when `sel_ba` = 0 and equals the B-to-A register when `sel_ba` = 1.
- R7: Both registers keep capturing while `oe_n` = 1. A value captured in that state appears at the output once it is enabled with the stored source selected.
- R8: `a_oe` and `b_oe` are never 1 at the same time.
- R9: A low level on `rst_n` clears both registers to zero at once, with no clock needed. It has no effect on `a_oe` or `b_oe`.
- R10: With the live source selected, a capture edge does not disturb the output. The output keeps showing the live value, and the same value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous clear of both registers, active low |
| clk_ab | input | 1 | Capture clock of the A-to-B register (rising edge) |
| clk_ba | input | 1 | Capture clock of the B-to-A register (rising edge) |
| oe_n | input | 1 | Output enable, active low |
| dir | input | 1 | 1 drives the B bus, 0 drives the A bus |
| sel_ab | input | 1 | Source for B bus: 0 live A, 1 stored A-to-B |
| sel_ba | input | 1 | Source for A bus: 0 live B, 1 stored B-to-A |
| a_in | input | WIDTH | Value sensed on the A bus |
| a_out | output | WIDTH | Value offered to the A bus |
| a_oe | output | 1 | Drive enable for the A bus |
| b_in | input | WIDTH | Value sensed on the B bus |
| b_out | output | WIDTH | Value offered to the B bus |
| b_oe | output | 1 | Drive enable for the B bus |

## Verification
A register that captures wrongly, or misses a capture, shows up at `b_out` or `a_out` on the first check after that edge where the stored source is selected. The bench selects the stored source often, so such a fault is found within a few steps. A faulty enable decode is combinational, so it shows at `a_oe` and `b_oe` in the same step as the control change that exposes it. A missed clear on reset shows as a non-zero stored output immediately after `rst_n` falls.

// File: rtl/regxcvr_pkg.sv
package regxcvr_pkg;

  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_sel_e;

  typedef struct packed {
    logic drive_a;
    logic drive_b;
  } drive_t;

  // Enable decode: active-low enable, dir high targets bus B.
  function automatic drive_t decode_drive(input logic oe_n, input logic dir);
    drive_t d;
    d.drive_b = ~oe_n & dir;
    d.drive_a = ~oe_n & ~dir;
    return d;
  endfunction

endpackage

// File: rtl/regxcvr_store.sv
module regxcvr_store #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic             armed
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= '0;
      armed <= 1'b0;
    end else begin
      q     <= d;
      armed <= 1'b1;
    end
  end

  // R1 for the A-to-B instance, R2 for the B-to-A instance
  AST_CAPTURE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (q == $past(d))); // R1

endmodule

// File: rtl/regxcvr_pick.sv
module regxcvr_pick #(
  parameter int WIDTH = 8
) (
  input  logic             sel,
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] held,
  output logic [WIDTH-1:0] y
);
  import regxcvr_pkg::*;

  function automatic logic [WIDTH-1:0] pick_src(input src_sel_e s,
                                                input logic [WIDTH-1:0] l,
                                                input logic [WIDTH-1:0] h);
    return (s == SRC_STORED) ? h : l;
  endfunction

  always_comb y = pick_src(src_sel_e'(sel), live, held);

endmodule

// File: rtl/regxcvr_drive.sv
module regxcvr_drive (
  input  logic oe_n,
  input  logic dir,
  output logic a_oe,
  output logic b_oe
);
  import regxcvr_pkg::*;

  drive_t drv;

  always_comb drv = decode_drive(oe_n, dir);

  assign a_oe = drv.drive_a;
  assign b_oe = drv.drive_b;

  always_comb begin
    if (!$isunknown({oe_n, dir, a_oe, b_oe})) begin
      AST_ONE_DRIVER: assert (!(a_oe && b_oe)); // R8
      if (oe_n) begin
        AST_ISOLATED: assert (!a_oe && !b_oe); // R3
      end else begin
        AST_DIR_PICK: assert ((b_oe == dir) && (a_oe == !dir)); // R4
      end
    end
  end

endmodule

// File: rtl/regxcvr_top.sv
module regxcvr_top #(
  parameter int WIDTH = 8
) (
  input  logic             rst_n,
  input  logic             clk_ab,
  input  logic             clk_ba,
  input  logic             oe_n,
  input  logic             dir,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe
);

  localparam int NDIR   = 2;
  localparam int DIR_AB = 0;
  localparam int DIR_BA = 1;

  // Per-direction wires, index DIR_AB or DIR_BA
  logic [NDIR-1:0]            cap_clk;
  logic [NDIR-1:0]            path_sel;
  logic [NDIR-1:0]            path_armed;
  logic [NDIR-1:0][WIDTH-1:0] path_live;
  logic [NDIR-1:0][WIDTH-1:0] path_held;
  logic [NDIR-1:0][WIDTH-1:0] path_y;

  assign cap_clk[DIR_AB]   = clk_ab;
  assign cap_clk[DIR_BA]   = clk_ba;
  assign path_sel[DIR_AB]  = sel_ab;
  assign path_sel[DIR_BA]  = sel_ba;
  assign path_live[DIR_AB] = a_in;
  assign path_live[DIR_BA] = b_in;

  for (genvar g = 0; g < NDIR; g++) begin : g_path
    regxcvr_store #(.WIDTH(WIDTH)) store_i (
      .clk   (cap_clk[g]),
      .rst_n (rst_n),
      .d     (path_live[g]),
      .q     (path_held[g]),
      .armed (path_armed[g])
    );
    regxcvr_pick #(.WIDTH(WIDTH)) pick_i (
      .sel  (path_sel[g]),
      .live (path_live[g]),
      .held (path_held[g]),
      .y    (path_y[g])
    );
  end

  assign b_out = path_y[DIR_AB];
  assign a_out = path_y[DIR_BA];

  regxcvr_drive drive_i (
    .oe_n (oe_n),
    .dir  (dir),
    .a_oe (a_oe),
    .b_oe (b_oe)
  );

  AST_AB_STORED_OUT: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (path_armed[DIR_AB] && sel_ab) |-> (b_out == $past(a_in))); // R5
  AST_BA_STORED_OUT: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (path_armed[DIR_BA] && sel_ba) |-> (a_out == $past(b_in))); // R6

endmodule

// File: tb/regxcvr_top_tb_top.sv
module regxcvr_top_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_n, clk_ab, clk_ba, oe_n, dir, sel_ab, sel_ba;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic         a_oe, b_oe;

  int           n_run  = 0;
  int           n_fail = 0;
  bit           done   = 0;
  logic [W-1:0] m_ab   = '0;
  logic [W-1:0] m_ba   = '0;

  regxcvr_top #(.WIDTH(W)) dut_i (
    .rst_n(rst_n), .clk_ab(clk_ab), .clk_ba(clk_ba), .oe_n(oe_n), .dir(dir),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  function automatic logic [W-1:0] f_out(input logic s, input logic [W-1:0] live,
                                         input logic [W-1:0] kept);
    if (s) return kept;
    return live;
  endfunction

  function automatic logic f_aoe(input logic en_n, input logic d);
    return (en_n == 1'b0) && (d == 1'b0);
  endfunction

  function automatic logic f_boe(input logic en_n, input logic d);
    return (en_n == 1'b0) && (d == 1'b1);
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string ctx);
    chk({ctx, " R5 b_out"}, b_out, f_out(sel_ab, a_in, m_ab));
    chk({ctx, " R6 a_out"}, a_out, f_out(sel_ba, b_in, m_ba));
    chk({ctx, " R3/R4 a_oe"}, W'(a_oe), W'(f_aoe(oe_n, dir)));
    chk({ctx, " R3/R4 b_oe"}, W'(b_oe), W'(f_boe(oe_n, dir)));
    chk({ctx, " R8 single driver"}, W'(a_oe & b_oe), '0);
  endtask

  // One step: drive at negedge, optional capture edges at posedge, check at next negedge.
  task automatic apply(input logic en_n, input logic d, input logic sab, input logic sba,
                       input logic [W-1:0] av, input logic [W-1:0] bv,
                       input logic pab, input logic pba);
    @(negedge clk);
    clk_ab = 1'b0; clk_ba = 1'b0;
    oe_n = en_n; dir = d; sel_ab = sab; sel_ba = sba; a_in = av; b_in = bv;
    @(posedge clk);
    if (pab) begin clk_ab = 1'b1; m_ab = a_in; end // R1
    if (pba) begin clk_ba = 1'b1; m_ba = b_in; end // R2
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    rst_n = 1'b0; clk_ab = 0; clk_ba = 0; oe_n = 1; dir = 0;
    sel_ab = 0; sel_ba = 0; a_in = '0; b_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9: reset state, stored sources selected
    apply(1'b0, 1'b1, 1'b1, 1'b1, 8'hA5, 8'h5A, 1'b0, 1'b0);
    chk("R9 reset b_out", b_out, 8'h00);
    chk("R9 reset a_out", a_out, 8'h00);
    check_all("reset");

    // R3/R4: every combination of enable, direction and both selects
    for (int k = 0; k < 16; k++) begin
      apply(k[0], k[1], k[2], k[3], 8'(k * 17), 8'(255 - k * 13), 1'b0, 1'b0);
      check_all("sweep");
    end

    // R7: capture in isolation, then reveal
    apply(1'b1, 1'b0, 1'b1, 1'b1, 8'hC3, 8'h96, 1'b1, 1'b1);
    chk("R7 isolated a_oe", W'(a_oe), '0);
    chk("R7 isolated b_oe", W'(b_oe), '0);
    apply(1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 8'hFF, 1'b0, 1'b0);
    chk("R7 R1 stored on b_out", b_out, 8'hC3);
    apply(1'b0, 1'b0, 1'b1, 1'b1, 8'h11, 8'h22, 1'b0, 1'b0);
    chk("R7 R2 stored on a_out", a_out, 8'h96);

    // R10: live pass and capture on the same edge
    apply(1'b0, 1'b1, 1'b0, 1'b0, 8'h3C, 8'h44, 1'b1, 1'b0);
    chk("R10 live b_out at capture", b_out, 8'h3C);
    apply(1'b0, 1'b1, 1'b1, 1'b0, 8'h81, 8'h44, 1'b0, 1'b0);
    chk("R10 R5 captured value held", b_out, 8'h3C);
    apply(1'b0, 1'b0, 1'b0, 1'b0, 8'h81, 8'h7E, 1'b0, 1'b1);
    chk("R10 live a_out at capture", a_out, 8'h7E);
    apply(1'b0, 1'b0, 1'b0, 1'b1, 8'h81, 8'h00, 1'b0, 1'b0);
    chk("R10 R6 captured value held", a_out, 8'h7E);

    // R9: asynchronous clear mid-run, enables unaffected
    @(negedge clk);
    oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1; sel_ba = 1'b1;
    #1 rst_n = 1'b0;
    m_ab = '0; m_ba = '0;
    #1;
    chk("R9 async clear b_out", b_out, 8'h00);
    chk("R9 async clear a_out", a_out, 8'h00);
    chk("R9 b_oe kept in reset", W'(b_oe), 8'h01);
    chk("R9 a_oe kept in reset", W'(a_oe), 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    // Random mix
    for (int i = 0; i < 400; i++) begin
      apply(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));
      check_all("random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule